// File: doc/BRIEF.md
# Boot ROM Overlay Address Decoder

This block sits between the CPU of an 8-bit handheld console and the things that answer its bus. The bus has a 16-bit address. For every read or write it picks exactly one of four targets: a 256-byte start-up ROM that overlays the lowest addresses, the cartridge port, the joypad register, or internal memory.

The selects are combinational, so a target sees its select in the same cycle as the strobe. The returned byte goes through one register and reaches the CPU in the following cycle, together with a valid flag.

At power-up the start-up ROM hides the first 256 bytes of cartridge space. Start-up code removes it by writing any non-zero byte to the lock address 0xFF50. The lock flag is sticky and only a reset clears it. From then on those low addresses read from the cartridge.

Top module: `boot_overlay_decoder`

## Requirements
- R1: After reset the overlay is active (`overlay_active`=1), all four selects are low, `cpu_rvalid` is 0 and `cpu_rdata` is 0x00.
- R2: While the overlay is active, a read of 0x0000–0x00FF asserts `boot_sel`, and the byte on `boot_rdata` is returned.
- R3: A write of any non-zero byte to 0xFF50 clears `overlay_active` from the next cycle onward. From then on, reads of 0x0000–0x00FF assert `cart_sel` and return `cart_rdata`.
- R4: Only reset clears the lock flag. A write of 0x00 to 0xFF50 has no effect on `overlay_active`, whether or not the lock is already set. A second non-zero write leaves the overlay off.
- R5: A write to 0x0000–0x00FF asserts `cart_sel` in either overlay state. `boot_sel` is never asserted during a write.
- R6: A read or write of 0x0000–0x7FFF (apart from the overlay read window of R2) or of 0xA000–0xBFFF asserts `cart_sel`.
- R7: A read of 0xFF00 asserts `joy_sel` and returns `joy_rdata`. A write to 0xFF00 asserts `imem_sel`.
- R8: Every other address asserts `imem_sel`. This covers 0x8000–0x9FFF, 0xC000–0xFEFF, 0xFF01–0xFFFF and 0xFF50 itself.
- R9: While `cpu_rd` or `cpu_wr` is high, exactly one of `boot_sel`, `cart_sel`, `joy_sel` and `imem_sel` is high. When both strobes are low, all four are low.
- R10: A read cycle sets `cpu_rvalid` in the next cycle, with `cpu_rdata` equal to the selected target's byte as sampled in the read cycle. After a cycle that is not a read, `cpu_rvalid` is 0 and `cpu_rdata` keeps its last value.
- R11: A cycle with both `cpu_rd` and `cpu_wr` high is decoded as a write only. It produces no read return, and it can set the lock as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU bus address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Registered read data |
| cpu_rvalid | output | 1 | Read data valid, one cycle after the read |
| boot_sel | output | 1 | Start-up ROM select |
| cart_sel | output | 1 | Cartridge port select |
| joy_sel | output | 1 | Joypad register select |
| imem_sel | output | 1 | Internal memory select |
| boot_rdata | input | 8 | Byte from the start-up ROM |
| cart_rdata | input | 8 | Byte from the cartridge port |
| joy_rdata | input | 8 | Joypad register value |
| imem_rdata | input | 8 | Byte from internal memory |
| overlay_active | output | 1 | 1 while the start-up ROM overlay is in force |

## Verification
The hardest state to reach is the lock flag after a series of lock-address writes. The flag has no read-back of its own, so its state shows only through `overlay_active` and through which target answers a low-address read. The stimulus therefore writes zero to 0xFF50 before the lock is set, sets it, and then writes zero and non-zero again. After each of these writes it reads 0x0000–0x00FF, so that the returned byte tells which target answered. Combined read-and-write cycles and reads issued back-to-back with no idle cycle between them are also driven. They check that the registered return stays in step with the select decode.

// File: rtl/bootdec_pkg.sv
package bootdec_pkg;
    // Target codes; also the index of each target in the return-data array.
    typedef enum logic [1:0] {
        TGT_BOOT = 2'd0,
        TGT_CART = 2'd1,
        TGT_JOY  = 2'd2,
        TGT_IMEM = 2'd3
    } target_e;

    localparam int NUM_TGT = 4;
endpackage

// File: rtl/bootdec_region.sv
module bootdec_region
    import bootdec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BOOT_BYTES = 256,
    parameter logic [ADDR_W-1:0] ROM_LIMIT = 16'h8000,
    parameter logic [ADDR_W-1:0] XRAM_LO = 16'hA000,
    parameter logic [ADDR_W-1:0] XRAM_HI = 16'hC000,
    parameter logic [ADDR_W-1:0] JOY_ADDR = 16'hFF00
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  logic              overlay_on,
    output target_e           tgt
);
    localparam logic [ADDR_W-1:0] BOOT_LIMIT = ADDR_W'(BOOT_BYTES);

    logic in_boot_d, in_rom_d, in_xram_d, is_joy_d;

    always_comb begin
        in_boot_d = (addr < BOOT_LIMIT);
        in_rom_d  = (addr < ROM_LIMIT);
        in_xram_d = (addr >= XRAM_LO) && (addr < XRAM_HI);
        is_joy_d  = (addr == JOY_ADDR);

        // Overlay only answers reads; writes fall through to the cartridge.
        if (in_boot_d && overlay_on && !is_write) begin
            tgt = TGT_BOOT;
        end else if (in_rom_d || in_xram_d) begin
            tgt = TGT_CART;
        end else if (is_joy_d && !is_write) begin
            tgt = TGT_JOY;
        end else begin
            tgt = TGT_IMEM;
        end
    end
endmodule

// File: rtl/bootdec_lock.sv
module bootdec_lock #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 16'hFF50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              overlay_on
);
    typedef struct packed {
        logic locked;
    } lock_t;

    lock_t lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        // Set-only: nothing but reset ever clears the flag.
        if (wr_en && (addr == LOCK_ADDR) && (wdata != '0)) begin
            lock_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else begin
            lock_q <= lock_d;
        end
    end

    assign overlay_on = !lock_q.locked;
endmodule

// File: rtl/bootdec_rdreg.sv
module bootdec_rdreg
    import bootdec_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_take,
    input  target_e                         tgt,
    input  logic [NUM_TGT-1:0][DATA_W-1:0]  src_data,
    output logic [DATA_W-1:0]               rdata,
    output logic                            rvalid
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } ret_t;

    ret_t ret_d, ret_q;

    always_comb begin
        ret_d       = ret_q;
        ret_d.valid = rd_take;
        if (rd_take) begin
            ret_d.data = src_data[tgt];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_q <= '0;
        end else begin
            ret_q <= ret_d;
        end
    end

    assign rdata  = ret_q.data;
    assign rvalid = ret_q.valid;
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
    import bootdec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int BOOT_BYTES = 256,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 16'hFF50,
    parameter logic [ADDR_W-1:0] JOY_ADDR = 16'hFF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    output logic              boot_sel,
    output logic              cart_sel,
    output logic              joy_sel,
    output logic              imem_sel,
    input  logic [DATA_W-1:0] boot_rdata,
    input  logic [DATA_W-1:0] cart_rdata,
    input  logic [DATA_W-1:0] joy_rdata,
    input  logic [DATA_W-1:0] imem_rdata,
    output logic              overlay_active
);
    logic                           access;
    logic                           rd_take;
    logic                           overlay_on;
    target_e                        tgt;
    logic [NUM_TGT-1:0]             sel;
    logic [NUM_TGT-1:0][DATA_W-1:0] src_data;

    assign access  = cpu_rd || cpu_wr;
    // A combined strobe is a write; it never returns data.
    assign rd_take = cpu_rd && !cpu_wr;

    bootdec_region #(
        .ADDR_W     (ADDR_W),
        .BOOT_BYTES (BOOT_BYTES),
        .JOY_ADDR   (JOY_ADDR)
    ) u_region (
        .addr       (cpu_addr),
        .is_write   (cpu_wr),
        .overlay_on (overlay_on),
        .tgt        (tgt)
    );

    bootdec_lock #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .LOCK_ADDR (LOCK_ADDR)
    ) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cpu_wr),
        .addr       (cpu_addr),
        .wdata      (cpu_wdata),
        .overlay_on (overlay_on)
    );

    assign src_data[int'(TGT_BOOT)] = boot_rdata;
    assign src_data[int'(TGT_CART)] = cart_rdata;
    assign src_data[int'(TGT_JOY)]  = joy_rdata;
    assign src_data[int'(TGT_IMEM)] = imem_rdata;

    bootdec_rdreg #(
        .DATA_W (DATA_W)
    ) u_rdreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_take  (rd_take),
        .tgt      (tgt),
        .src_data (src_data),
        .rdata    (cpu_rdata),
        .rvalid   (cpu_rvalid)
    );

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_sel
        assign sel[g] = access && (tgt == target_e'(g));
    end

    assign boot_sel       = sel[int'(TGT_BOOT)];
    assign cart_sel       = sel[int'(TGT_CART)];
    assign joy_sel        = sel[int'(TGT_JOY)];
    assign imem_sel       = sel[int'(TGT_IMEM)];
    assign overlay_active = overlay_on;
endmodule

// File: rtl/bootdec_checker.sv
module bootdec_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              cpu_rvalid,
    input logic              boot_sel,
    input logic              cart_sel,
    input logic              joy_sel,
    input logic              imem_sel,
    input logic [DATA_W-1:0] boot_rdata,
    input logic              overlay_active
);
    assert_one_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd || cpu_wr) |-> $onehot({boot_sel, cart_sel, joy_sel, imem_sel}));

    assert_idle_nosel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd || cpu_wr) |-> ({boot_sel, cart_sel, joy_sel, imem_sel} == 4'b0000));

    assert_lock_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'hFF50 && cpu_wdata != '0) |=> !overlay_active);

    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !overlay_active |=> !overlay_active);

    assert_boot_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && overlay_active && cpu_addr < 16'h0100) |-> boot_sel);

    assert_no_boot_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |-> !boot_sel);

    assert_xram_cart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd || cpu_wr) && cpu_addr >= 16'hA000 && cpu_addr < 16'hC000) |-> cart_sel);

    assert_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr) |=> cpu_rvalid);

    assert_no_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd && !cpu_wr) |=> !cpu_rvalid);

    assert_boot_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_sel && cpu_rd && !cpu_wr) |=> (cpu_rdata == $past(boot_rdata)));
endmodule

bind boot_overlay_decoder bootdec_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_bootdec_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_addr       (cpu_addr),
    .cpu_wdata      (cpu_wdata),
    .cpu_rd         (cpu_rd),
    .cpu_wr         (cpu_wr),
    .cpu_rdata      (cpu_rdata),
    .cpu_rvalid     (cpu_rvalid),
    .boot_sel       (boot_sel),
    .cart_sel       (cart_sel),
    .joy_sel        (joy_sel),
    .imem_sel       (imem_sel),
    .boot_rdata     (boot_rdata),
    .overlay_active (overlay_active)
);

// File: tb/boot_overlay_decoder_tb_top.sv
module boot_overlay_decoder_tb_top;
    localparam int T_BOOT = 0;
    localparam int T_CART = 1;
    localparam int T_JOY  = 2;
    localparam int T_IMEM = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rvalid;
    logic        boot_sel, cart_sel, joy_sel, imem_sel;
    logic [7:0]  boot_rdata, cart_rdata, joy_rdata, imem_rdata;
    logic        overlay_active;
    logic [7:0]  joy_val = 8'h1E;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    // Target stubs: each answers with a distinct function of the address.
    function automatic logic [7:0] stub(int t, logic [15:0] a);
        case (t)
            T_BOOT:  return a[7:0] ^ 8'hA5;
            T_CART:  return a[7:0] ^ a[15:8] ^ 8'h5A;
            T_JOY:   return joy_val;
            default: return a[7:0] + a[15:8] + 8'h11;
        endcase
    endfunction

    assign boot_rdata = stub(T_BOOT, cpu_addr);
    assign cart_rdata = stub(T_CART, cpu_addr);
    assign joy_rdata  = joy_val;
    assign imem_rdata = stub(T_IMEM, cpu_addr);

    boot_overlay_decoder dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_addr       (cpu_addr),
        .cpu_wdata      (cpu_wdata),
        .cpu_rd         (cpu_rd),
        .cpu_wr         (cpu_wr),
        .cpu_rdata      (cpu_rdata),
        .cpu_rvalid     (cpu_rvalid),
        .boot_sel       (boot_sel),
        .cart_sel       (cart_sel),
        .joy_sel        (joy_sel),
        .imem_sel       (imem_sel),
        .boot_rdata     (boot_rdata),
        .cart_rdata     (cart_rdata),
        .joy_rdata      (joy_rdata),
        .imem_rdata     (imem_rdata),
        .overlay_active (overlay_active)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver: one access per call, selects checked in the same cycle,
    // expected read data pushed for the monitor.
    task automatic access(string tag, logic [15:0] a, bit rd, bit wr,
                          logic [7:0] wd, int exp_t);
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
        #1;
        check({tag, " sel"}, {28'd0, imem_sel, joy_sel, cart_sel, boot_sel},
              32'(1) << exp_t);
        if (rd && !wr) begin
            exp_q.push_back(stub(exp_t, a));
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        #1;
    endtask

    // Monitor: compares every returned byte against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cpu_rvalid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R10 unexpected return: actual %0h expected none", cpu_rdata);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    if (cpu_rdata !== e) begin
                        errors++;
                        $display("FAIL %s data: actual %0h expected %0h", t, cpu_rdata, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 overlay", 32'(overlay_active), 32'd1);
        check("R1 sels", {28'd0, imem_sel, joy_sel, cart_sel, boot_sel}, 32'd0);
        check("R1 rvalid", 32'(cpu_rvalid), 32'd0);
        check("R1 rdata", 32'(cpu_rdata), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Overlay window and cartridge/memory/joypad decode, back-to-back reads.
        access("R2 0000", 16'h0000, 1, 0, 0, T_BOOT);
        access("R2 0042", 16'h0042, 1, 0, 0, T_BOOT);
        access("R2 00FF", 16'h00FF, 1, 0, 0, T_BOOT);
        access("R6 0100", 16'h0100, 1, 0, 0, T_CART);
        access("R6 4000", 16'h4000, 1, 0, 0, T_CART);
        access("R6 7FFF", 16'h7FFF, 1, 0, 0, T_CART);
        access("R6 A000", 16'hA000, 1, 0, 0, T_CART);
        access("R6 BFFF", 16'hBFFF, 1, 0, 0, T_CART);
        access("R8 8000", 16'h8000, 1, 0, 0, T_IMEM);
        access("R8 9FFF", 16'h9FFF, 1, 0, 0, T_IMEM);
        access("R8 C000", 16'hC000, 1, 0, 0, T_IMEM);
        access("R8 FF50", 16'hFF50, 1, 0, 0, T_IMEM);
        access("R8 FFFF", 16'hFFFF, 1, 0, 0, T_IMEM);
        access("R7 FF00 rd", 16'hFF00, 1, 0, 0, T_JOY);
        idle();
        joy_val = 8'hE7;
        access("R7 FF00 rd2", 16'hFF00, 1, 0, 0, T_JOY);
        access("R8 FF01", 16'hFF01, 1, 0, 0, T_IMEM);
        idle();
        check("R9 idle sels", {28'd0, imem_sel, joy_sel, cart_sel, boot_sel}, 32'd0);
        check("R10 hold rdata", 32'(cpu_rdata), 32'(stub(T_IMEM, 16'hFF01)));

        // Writes.
        access("R5 wr 0010", 16'h0010, 0, 1, 8'h77, T_CART);
        access("R7 wr FF00", 16'hFF00, 0, 1, 8'h30, T_IMEM);
        check("R10 no rvalid after write", 32'(cpu_rvalid), 32'd0);
        access("R6 wr A123", 16'hA123, 0, 1, 8'h12, T_CART);
        access("R8 wr 9000", 16'h9000, 0, 1, 8'h34, T_IMEM);
        access("R2 0010 after wr", 16'h0010, 1, 0, 0, T_BOOT);

        // Zero to the lock address before the lock is set.
        access("R4 wr0 FF50", 16'hFF50, 0, 1, 8'h00, T_IMEM);
        idle();
        check("R4 overlay after zero", 32'(overlay_active), 32'd1);
        access("R4 0000 still boot", 16'h0000, 1, 0, 0, T_BOOT);

        // Combined strobes decode as write only.
        access("R11 rdwr 0020", 16'h0020, 1, 1, 8'h00, T_CART);
        idle();
        check("R11 no rvalid", 32'(cpu_rvalid), 32'd0);
        access("R11 rdwr FF00", 16'hFF00, 1, 1, 8'h00, T_IMEM);

        // Set the lock.
        access("R3 wr FF50", 16'hFF50, 0, 1, 8'h01, T_IMEM);
        idle();
        check("R3 overlay off", 32'(overlay_active), 32'd0);
        access("R3 0000 cart", 16'h0000, 1, 0, 0, T_CART);
        access("R3 00FF cart", 16'h00FF, 1, 0, 0, T_CART);
        access("R5 wr 0001 locked", 16'h0001, 0, 1, 8'h55, T_CART);

        // Sticky lock.
        access("R4 wr0 after lock", 16'hFF50, 0, 1, 8'h00, T_IMEM);
        idle();
        check("R4 stays off", 32'(overlay_active), 32'd0);
        access("R4 wr80 after lock", 16'hFF50, 0, 1, 8'h80, T_IMEM);
        idle();
        check("R4 stays off 2", 32'(overlay_active), 32'd0);
        access("R4 0005 cart", 16'h0005, 1, 0, 0, T_CART);
        access("R10 C001", 16'hC001, 1, 0, 0, T_IMEM);
        access("R7 FF00 locked", 16'hFF00, 1, 0, 0, T_JOY);
        idle();
        idle();

        // Reset brings the overlay back.
        rst_n = 1'b0;
        #1;
        check("R1 overlay re-reset", 32'(overlay_active), 32'd1);
        check("R1 rvalid re-reset", 32'(cpu_rvalid), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        access("R1 0000 boot again", 16'h0000, 1, 0, 0, T_BOOT);
        idle();
        idle();

        check("R10 scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end
endmodule